// File: doc/BRIEF.md
# Run-Length Command Byte Expander

This block sits on the peripheral side of an enhanced parallel port link. It takes a stream of received bytes. Each byte carries a flag that marks it as data or as a command. A command byte either sets a repeat count or selects a channel. When a repeat count is pending, the next data byte is expanded into several identical output bytes. Every other data byte goes through unchanged. The result is a plain byte stream with a valid/ready handshake. The block also keeps the most recently selected channel in a register and pulses a strobe whenever that register is loaded.

The input side is ready only when the single output holding register is free, or when the last copy of its byte is leaving in the current cycle. While a run is being expanded, the block holds off the input. It sends one copy per cycle for as long as the consumer is ready. Command bytes never produce output bytes.

Top module: `rle_byte_expander`

## Requirements
- R1: A command byte (in_is_cmd=1) with bit 7 equal to 0 is a run count. Bits 6:0 hold a count N from 0 to 127, which is stored as pending.
- R2: A command byte with bit 7 equal to 1 loads bits 6:0 into chan_addr. chan_addr shows the new value in the cycle after acceptance, and chan_stb is high for exactly that one cycle.
- R3: When a count N is pending, the next accepted data byte appears as exactly N+1 consecutive output transfers of that byte. N=24 gives 25 transfers and N=127 gives 128.
- R4: A data byte accepted with no count pending produces exactly one output transfer. The count is consumed by the first data byte only, so later data bytes come out once each and in order.
- R5: A second run count accepted before any data byte replaces the pending count instead of adding to it.
- R6: An accepted channel command leaves a pending run count untouched.
- R7: in_ready is 1 exactly when no byte is held for output, or when the held byte is on its last copy and out_ready is 1. At most one output byte moves per cycle.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_byte does not change in the next cycle.
- R9: A synchronous active-high reset clears the held byte, the pending count and the strobe, and sets chan_addr to 0. After reset, in_ready is 1.
- R10: Command bytes of either kind cause no output transfer of their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte offered |
| in_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| in_byte | input | 8 | Received byte |
| in_ready | output | 1 | Input byte accepted when in_valid and in_ready are both 1 |
| out_valid | output | 1 | Output byte present |
| out_byte | output | 8 | Expanded output byte |
| out_ready | input | 1 | Consumer takes the output byte |
| chan_addr | output | 7 | Last channel selected by a command |
| chan_stb | output | 1 | One-cycle pulse after a channel load |

## Verification
A repeat counter that is off by one would add or drop a single copy at the end of a run. That error is visible at the next data byte: the output stream gets out of step with the expected sequence as soon as the run ends. A pending flag that is cleared wrongly or left set would make a later data byte come out a different number of times. Reset and a stalled consumer give fixed patterns that can be compared on every cycle. The bench therefore compares every output transfer, and the in_ready level on every cycle, against a reference queue.

// File: rtl/rle_pkg.sv
package rle_pkg;
    parameter int BYTE_W = 8;
    localparam int FIELD_W = BYTE_W - 1;

    typedef enum logic {
        CMD_RUN  = 1'b0,
        CMD_CHAN = 1'b1
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e            kind;
        logic [FIELD_W-1:0]   field;
    } cmd_t;

    function automatic cmd_t split_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.kind  = cmd_kind_e'(b[BYTE_W-1]);
        c.field = b[FIELD_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/rle_cmd_decode.sv
module rle_cmd_decode
    import rle_pkg::*;
(
    input  logic                take,
    input  logic                is_cmd,
    input  logic [BYTE_W-1:0]   b,
    output logic                load_run,
    output logic                load_chan,
    output logic                load_data,
    output logic [FIELD_W-1:0]  field
);
    cmd_t c;

    always_comb begin
        c         = split_cmd(b);
        field     = c.field;
        load_run  = take && is_cmd && (c.kind == CMD_RUN);
        load_chan = take && is_cmd && (c.kind == CMD_CHAN);
        load_data = take && !is_cmd;
    end
endmodule

// File: rtl/rle_chan_reg.sv
module rle_chan_reg
    import rle_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [FIELD_W-1:0]  field,
    output logic [FIELD_W-1:0]  chan_addr,
    output logic                chan_stb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chan_addr <= '0;
            chan_stb  <= 1'b0;
        end else begin
            chan_stb <= load;
            if (load) chan_addr <= field;
        end
    end

    // R2
    chan_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> chan_stb && chan_addr == $past(field));

    // R2
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> !chan_stb && $stable(chan_addr));
endmodule

// File: rtl/rle_run_engine.sv
module rle_run_engine
    import rle_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_run,
    input  logic [FIELD_W-1:0]  run_val,
    input  logic                load_data,
    input  logic [BYTE_W-1:0]   data_in,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [BYTE_W-1:0]   out_byte,
    output logic                accept_ok
);
    logic                pend_v;
    logic [FIELD_W-1:0]  pend_cnt;
    logic                hold_v;
    logic [BYTE_W-1:0]   hold_byte;
    logic [FIELD_W-1:0]  rem;
    logic                last_copy;
    logic                move;

    always_comb begin
        last_copy = (rem == '0);
        move      = hold_v && out_ready;
        accept_ok = !hold_v || (out_ready && last_copy);
        out_valid = hold_v;
        out_byte  = hold_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_cnt  <= '0;
            hold_v    <= 1'b0;
            hold_byte <= '0;
            rem       <= '0;
        end else begin
            if (load_run) begin
                pend_v   <= 1'b1;
                pend_cnt <= run_val;
            end
            if (load_data) begin
                hold_v    <= 1'b1;
                hold_byte <= data_in;
                rem       <= pend_v ? pend_cnt : '0;
                pend_v    <= 1'b0;
            end else if (move) begin
                if (last_copy) hold_v <= 1'b0;
                else           rem    <= rem - 1'b1;
            end
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_byte));

    // R3
    repeat_chk: assert property (@(posedge clk) disable iff (rst)
        move && !last_copy |=> out_valid && $stable(out_byte));

    // R4
    single_chk: assert property (@(posedge clk) disable iff (rst)
        load_data && !pend_v |=> out_valid && out_byte == $past(data_in) && last_copy);
endmodule

// File: rtl/rle_byte_expander.sv
module rle_byte_expander
    import rle_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_is_cmd,
    input  logic [7:0]         in_byte,
    output logic               in_ready,
    output logic               out_valid,
    output logic [7:0]         out_byte,
    input  logic               out_ready,
    output logic [6:0]         chan_addr,
    output logic               chan_stb
);
    logic                take;
    logic                load_run;
    logic                load_chan;
    logic                load_data;
    logic [FIELD_W-1:0]  field;

    assign take = in_valid && in_ready;

    rle_cmd_decode u_dec (
        .take      (take),
        .is_cmd    (in_is_cmd),
        .b         (in_byte),
        .load_run  (load_run),
        .load_chan (load_chan),
        .load_data (load_data),
        .field     (field)
    );

    rle_chan_reg u_chan (
        .clk       (clk),
        .rst       (rst),
        .load      (load_chan),
        .field     (field),
        .chan_addr (chan_addr),
        .chan_stb  (chan_stb)
    );

    rle_run_engine u_run (
        .clk       (clk),
        .rst       (rst),
        .load_run  (load_run),
        .run_val   (field),
        .load_data (load_data),
        .data_in   (in_byte),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .accept_ok (in_ready)
    );

    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid && chan_addr == 7'd0 && !chan_stb);

    // R10
    cmd_no_out_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_is_cmd && !out_valid |=> !out_valid);
endmodule

// File: tb/sim_rle_byte_expander.sv
module sim_rle_byte_expander;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_is_cmd = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_ready = 1'b0;
    logic [6:0] chan_addr;
    logic       chan_stb;

    always #10 clk = ~clk;

    rle_byte_expander u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_cmd(in_is_cmd),
        .in_byte(in_byte), .in_ready(in_ready), .out_valid(out_valid),
        .out_byte(out_byte), .out_ready(out_ready), .chan_addr(chan_addr),
        .chan_stb(chan_stb)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [8:0] stim[$];
    logic [7:0] expq[$];
    logic [8:0] cur;
    bit         holding = 0;
    bit         mpend = 0;
    int         mcnt = 0;
    logic [6:0] exp_chan = 7'd0;
    bit         exp_stb = 0;
    int         out_count = 0;
    int         rdy_pct = 100;
    bit         prev_stall = 0;
    logic [7:0] prev_byte = 8'h00;
    string      tag = "R4";

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [8:0] run_cmd(input int n);
        return {1'b1, 1'b0, n[6:0]};
    endfunction
    function automatic logic [8:0] chan_cmd(input int a);
        return {1'b1, 1'b1, a[6:0]};
    endfunction
    function automatic logic [8:0] dat(input int b);
        return {1'b0, b[7:0]};
    endfunction

    task automatic step();
        @(negedge clk);
        chk(chan_stb == exp_stb, "R2", "chan_stb", int'(chan_stb), int'(exp_stb));
        chk(chan_addr == exp_chan, "R2", "chan_addr", int'(chan_addr), int'(exp_chan));
        chk(out_valid == (expq.size() != 0), tag, "out_valid", int'(out_valid), int'(expq.size() != 0));
        if (prev_stall)
            chk(out_valid && out_byte == prev_byte, "R8", "stalled byte", int'(out_byte), int'(prev_byte));
        if (!holding && stim.size() > 0) begin
            cur = stim.pop_front();
            holding = 1;
        end
        in_valid  = holding;
        in_is_cmd = cur[8];
        in_byte   = cur[7:0];
        out_ready = (($urandom % 100) < rdy_pct);
        #1;
        chk(in_ready == (expq.size() == 0 || (expq.size() == 1 && out_ready)), "R7", "in_ready",
            int'(in_ready), int'(expq.size() == 0 || (expq.size() == 1 && out_ready)));
        prev_stall = out_valid && !out_ready;
        prev_byte  = out_byte;
        if (out_valid && out_ready) begin
            logic [7:0] e;
            e = (expq.size() > 0) ? expq.pop_front() : 8'hxx;
            chk(out_byte == e, tag, "out_byte", int'(out_byte), int'(e));
            out_count++;
        end
        exp_stb = 0;
        if (in_valid && in_ready) begin
            holding = 0;
            if (cur[8] && !cur[7]) begin
                mpend = 1; mcnt = int'(cur[6:0]);
            end else if (cur[8]) begin
                exp_chan = cur[6:0]; exp_stb = 1;
            end else begin
                for (int k = 0; k <= (mpend ? mcnt : 0); k++) expq.push_back(cur[7:0]);
                mpend = 0;
            end
        end
    endtask

    task automatic drain();
        while (stim.size() > 0 || holding || expq.size() > 0) step();
        step();
    endtask

    task automatic directed(input string t, input int exp_n);
        int base;
        base = out_count;
        tag = t;
        drain();
        chk(out_count - base == exp_n, t, "transfer count", out_count - base, exp_n);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_valid = 0; out_ready = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        stim.delete(); expq.delete();
        holding = 0; mpend = 0; mcnt = 0; exp_chan = 7'd0; exp_stb = 0; prev_stall = 0;
        #1;
        chk(!out_valid, "R9", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready, "R9", "in_ready after reset", int'(in_ready), 1);
        chk(chan_addr == 7'd0, "R9", "chan_addr after reset", int'(chan_addr), 0);
        chk(!chan_stb, "R9", "chan_stb after reset", int'(chan_stb), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        cur = 9'd0;
        repeat (3) @(negedge clk);
        do_reset();

        rdy_pct = 100;
        stim.push_back(run_cmd(24)); stim.push_back(dat(8'h41));
        directed("R3", 25);
        stim.push_back(run_cmd(127)); stim.push_back(dat(8'h7E));
        directed("R1", 128);
        stim.push_back(run_cmd(2)); stim.push_back(dat(8'h11));
        stim.push_back(dat(8'h22)); stim.push_back(dat(8'h33));
        directed("R4", 5);
        stim.push_back(run_cmd(5)); stim.push_back(run_cmd(1)); stim.push_back(dat(8'h44));
        directed("R5", 2);
        stim.push_back(run_cmd(3)); stim.push_back(chan_cmd(8'h85)); stim.push_back(dat(8'h55));
        directed("R6", 4);
        chk(chan_addr == 7'h05, "R6", "channel kept", int'(chan_addr), 5);
        stim.push_back(chan_cmd(127)); stim.push_back(run_cmd(9));
        directed("R10", 0);
        stim.push_back(dat(8'h66));
        directed("R1", 10);

        rdy_pct = 40;
        stim.push_back(run_cmd(6)); stim.push_back(dat(8'h99)); stim.push_back(dat(8'h9A));
        directed("R8", 8);

        stim.push_back(run_cmd(5));
        drain();
        do_reset();
        rdy_pct = 100;
        stim.push_back(dat(8'h77));
        directed("R9", 1);

        rdy_pct = 70;
        tag = "R4";
        for (int i = 0; i < 3000; i++) begin
            if (stim.size() == 0) begin
                int r;
                r = int'($urandom % 10);
                if (r < 2)      stim.push_back(run_cmd(int'($urandom % 8)));
                else if (r < 3) stim.push_back(chan_cmd(int'($urandom % 128)));
                else            stim.push_back(dat(int'($urandom % 256)));
            end
            step();
        end
        drain();

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule